// File: doc/BRIEF.md
# Proximity Threshold Interrupt with Persistence Filter

This block watches the stream of finished 16-bit proximity results and decides when the host must be interrupted. Each result that arrives with its valid strobe is compared with a programmable window made of a lower and an upper bound. A result outside the window adds one to a count of consecutive out-of-window results. A result inside the window sets that count back to zero. When the count reaches a programmed persistence value, a latched interrupt is raised. A persistence of zero instead raises the interrupt on every completed result.

Once raised, the interrupt stays raised until the host issues an explicit clear pulse. That pulse also zeroes the consecutive count. The interrupt is seen in two ways: as an active-low pin that is pulled low while the interrupt is pending and released otherwise, and as an active-high flag that a status register can return. The conversion itself and the register access path are outside this block. The thresholds, persistence and enable arrive as plain inputs that are already assembled from their byte registers.

Top module: `prox_irq_filter`

## Requirements
- R1: A result is out of window when it is strictly greater than `thr_hi` or strictly less than `thr_lo`. A result equal to either bound is inside the window.
- R2: With `pers_cfg` = 0 and `irq_en` = 1, every result strobed by `res_valid` raises `irq_flag`, whether it is inside or outside the window. The flag is visible from the clock edge that samples the strobe.
- R3: With `pers_cfg` = N (1 to 15), `irq_flag` rises on the Nth consecutive out-of-window result and not on any earlier one.
- R4: An in-window result resets the consecutive count to zero, so a run broken by one in-window result must start again from zero.
- R5: The consecutive count saturates at 15 and never wraps. It advances on every strobed result whatever the value of `irq_en`.
- R6: Once set, `irq_flag` stays at 1 until a clear pulse is applied, whatever results arrive later. Dropping `irq_en` does not clear it.
- R7: While `irq_en` = 0, `irq_flag` never rises.
- R8: A one-cycle `irq_clr` pulse with no result in the same cycle makes `irq_flag` 0 and zeroes the consecutive count.
- R9: When `irq_clr` and `res_valid` arrive in the same cycle, the clear is applied first and the new result is then evaluated on top of it. The count restarts from this result alone, and `irq_flag` ends at 1 if and only if this result qualifies on that basis.
- R10: After reset, `irq_flag` is 0 and `irq_n` is 1. At all times `irq_n` is 0 exactly when `irq_flag` is 1; the released pin is modelled as logic 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| res_valid | input | 1 | Strobe: a proximity result is complete this cycle |
| res_value | input | 16 | Completed proximity result |
| thr_lo | input | 16 | Lower window bound |
| thr_hi | input | 16 | Upper window bound |
| pers_cfg | input | 4 | Persistence: 0 means every result, N means N consecutive out-of-window results |
| irq_en | input | 1 | Interrupt generation enable |
| irq_clr | input | 1 | One-cycle clear command for the latched interrupt and the count |
| irq_n | output | 1 | Interrupt pin, active low, 1 when released |
| irq_flag | output | 1 | Interrupt pending flag for status readback |

## Verification
The window comparison is driven with results placed at each bound and one step beyond it. This separates strict comparisons from inclusive ones.

The persistence filter is exercised in several ways:
- Runs just one short of N and exactly N long, which expose an off-by-one in the count.
- A run broken by a single in-window result, which shows whether the count is reset or only held.
- More than sixteen out-of-window results taken while the interrupt is disabled, which tells saturation apart from wrap-around.

The clear is tested both on its own and in the same cycle as a qualifying or non-qualifying result. This pins down which of the two takes precedence.

// File: rtl/prox_irq_pkg.sv
package prox_irq_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PERS_W = 4;
  typedef logic [DATA_W-1:0] result_t;
  typedef logic [PERS_W-1:0] pers_t;
endpackage

// File: rtl/prox_window_cmp.sv
module prox_window_cmp #(
  parameter int unsigned DATA_W = prox_irq_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              outside
);
  logic above_hi;
  logic below_lo;

  always_comb begin
    above_hi = (value > hi);
    below_lo = (value < lo);
    outside  = above_hi | below_lo;
  end
endmodule

// File: rtl/prox_run_counter.sv
module prox_run_counter #(
  parameter int unsigned PERS_W = prox_irq_pkg::PERS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              outside,
  input  logic              clr,
  output logic [PERS_W-1:0] cnt_next,
  output logic [PERS_W-1:0] cnt_q
);
  localparam logic [PERS_W-1:0] CNT_MAX = {PERS_W{1'b1}};

  logic [PERS_W-1:0] base;
  logic              cnt_en;

  // Next-state: the clear is applied first, then a strobed result updates the count.
  always_comb begin
    base   = clr ? '0 : cnt_q;
    cnt_en = step | clr;
    if (step) begin
      if (outside) begin
        cnt_next = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
      end else begin
        cnt_next = '0;
      end
    end else begin
      cnt_next = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/prox_irq_latch.sv
module prox_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);
  logic pend_next;
  logic pend_en;

  // Next-state: a set in the same cycle as a clear wins.
  always_comb begin
    pend_en   = set | clr;
    pend_next = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (pend_en) begin
      pending <= pend_next;
    end
  end
endmodule

// File: rtl/prox_irq_filter.sv
module prox_irq_filter
  import prox_irq_pkg::*;
#(
  parameter int unsigned DATA_W = prox_irq_pkg::DATA_W,
  parameter int unsigned PERS_W = prox_irq_pkg::PERS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_value,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [PERS_W-1:0] pers_cfg,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              irq_n,
  output logic              irq_flag
);
  logic              outside;
  logic [PERS_W-1:0] cnt_next;
  logic [PERS_W-1:0] cnt_q;
  logic              every_mode;
  logic              run_met;
  logic              qualify;
  logic              pending;

  prox_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value   (res_value),
    .lo      (thr_lo),
    .hi      (thr_hi),
    .outside (outside)
  );

  prox_run_counter #(.PERS_W(PERS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (res_valid),
    .outside  (outside),
    .clr      (irq_clr),
    .cnt_next (cnt_next),
    .cnt_q    (cnt_q)
  );

  always_comb begin
    every_mode = (pers_cfg == '0);
    run_met    = outside && (cnt_next >= pers_cfg);
    qualify    = res_valid && irq_en && (every_mode || run_met);
  end

  prox_irq_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (qualify),
    .clr     (irq_clr),
    .pending (pending)
  );

  // Open-drain style pin: pulled low while pending, released (1) otherwise.
  always_comb begin
    irq_flag = pending;
    irq_n    = ~pending;
  end
endmodule

// File: rtl/prox_irq_filter_chk.sv
module prox_irq_filter_chk #(
  parameter int unsigned DATA_W = prox_irq_pkg::DATA_W,
  parameter int unsigned PERS_W = prox_irq_pkg::PERS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_value,
  input logic [DATA_W-1:0] thr_lo,
  input logic [DATA_W-1:0] thr_hi,
  input logic [PERS_W-1:0] pers_cfg,
  input logic              irq_en,
  input logic              irq_clr,
  input logic              irq_n,
  input logic              irq_flag
);
  logic in_win;
  assign in_win = (res_value >= thr_lo) && (res_value <= thr_hi);

  // R6: sticky until a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  // R7: no rise while disabled
  p_no_gen_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag && !irq_en |=> !irq_flag);

  // R8: lone clear drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !res_valid |=> !irq_flag);

  // R2: every-result mode
  p_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && irq_en && (pers_cfg == '0) |=> irq_flag);

  // R1: an in-window result never raises the flag when persistence is nonzero
  p_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && in_win && (pers_cfg != '0) && !irq_flag |=> !irq_flag);

  // R10: a rise always follows a strobed, enabled result
  p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(res_valid) && $past(irq_en));

  // R10: pin and flag are complementary
  always_comb begin
    if (rst_n) begin
      p_pin_r10: assert (irq_n != irq_flag);
    end
  end
endmodule

bind prox_irq_filter prox_irq_filter_chk #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_value (res_value),
  .thr_lo    (thr_lo),
  .thr_hi    (thr_hi),
  .pers_cfg  (pers_cfg),
  .irq_en    (irq_en),
  .irq_clr   (irq_clr),
  .irq_n     (irq_n),
  .irq_flag  (irq_flag)
);

// File: tb/tb_prox_irq_filter.sv
`timescale 1ns/1ps
module tb_prox_irq_filter;
  logic        clk;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_value;
  logic [15:0] thr_lo;
  logic [15:0] thr_hi;
  logic [3:0]  pers_cfg;
  logic        irq_en;
  logic        irq_clr;
  logic        irq_n;
  logic        irq_flag;

  int total;
  int bad;
  bit done;

  prox_irq_filter dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_value (res_value),
    .thr_lo    (thr_lo),
    .thr_hi    (thr_hi),
    .pers_cfg  (pers_cfg),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .irq_n     (irq_n),
    .irq_flag  (irq_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Compares flag and pin against the expected flag (R10 pin relation included).
  task automatic check(input string tag, input bit exp);
    total++;
    if (irq_flag !== exp || irq_n !== !exp) begin
      bad++;
      $display("FAIL %s: flag=%b pin=%b expected flag=%b pin=%b",
               tag, irq_flag, irq_n, exp, !exp);
    end
  endtask

  // One strobed result; outputs are read on the following falling edge.
  task automatic push(input logic [15:0] v);
    @(negedge clk);
    res_value = v;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic push_with_clear(input logic [15:0] v);
    @(negedge clk);
    res_value = v;
    res_valid = 1'b1;
    irq_clr   = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    irq_clr   = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset state", 1'b0);
  endtask

  task automatic t_bounds();
    thr_lo = 16'd100; thr_hi = 16'd200; pers_cfg = 4'd1; irq_en = 1'b1;
    push(16'd100); check("R1 equal low bound in window", 1'b0);
    push(16'd200); check("R1 equal high bound in window", 1'b0);
    push(16'd201); check("R1 above high bound", 1'b1);
    clear_pulse(); check("R8 clear after high", 1'b0);
    push(16'd99);  check("R1 below low bound", 1'b1);
    clear_pulse();
  endtask

  task automatic t_every();
    pers_cfg = 4'd0;
    push(16'd150); check("R2 in-window result with persistence 0", 1'b1);
    clear_pulse(); check("R8 clear in mode 0", 1'b0);
    push(16'd5000); check("R2 out-of-window result with persistence 0", 1'b1);
    clear_pulse();
  endtask

  task automatic t_persist();
    pers_cfg = 4'd3;
    push(16'd300); push(16'd10);
    check("R3 two of three", 1'b0);
    push(16'd300); check("R3 third consecutive", 1'b1);
    clear_pulse();
  endtask

  task automatic t_break();
    pers_cfg = 4'd3;
    push(16'd300); push(16'd300); push(16'd150);
    push(16'd300); push(16'd300);
    check("R4 run broken by in-window result", 1'b0);
    push(16'd300); check("R4 fresh run of three", 1'b1);
    clear_pulse();
  endtask

  task automatic t_sat();
    pers_cfg = 4'd15; irq_en = 1'b0;
    for (int i = 0; i < 17; i++) push(16'd900);
    check("R7 no rise while disabled", 1'b0);
    irq_en = 1'b1;
    push(16'd900); check("R5 count saturated at 15 not wrapped", 1'b1);
    clear_pulse();
  endtask

  task automatic t_sticky();
    pers_cfg = 4'd1;
    push(16'd900);
    push(16'd150); check("R6 stays after in-window result", 1'b1);
    irq_en = 1'b0;
    @(negedge clk); check("R6 stays after enable dropped", 1'b1);
    clear_pulse(); check("R8 clear while disabled", 1'b0);
    irq_en = 1'b1;
  endtask

  task automatic t_clear_count();
    pers_cfg = 4'd3;
    push(16'd900); push(16'd900);
    clear_pulse();
    push(16'd900); push(16'd900);
    check("R8 clear zeroed the count", 1'b0);
    push(16'd900); check("R8 run after clear", 1'b1);
    clear_pulse();
  endtask

  task automatic t_clr_same();
    pers_cfg = 4'd2;
    push(16'd900);
    push_with_clear(16'd900);
    check("R9 count restarts with the simultaneous result", 1'b0);
    push(16'd900); check("R9 second of the new run", 1'b1);
    pers_cfg = 4'd1;
    push_with_clear(16'd900);
    check("R9 qualifying result beats clear", 1'b1);
    push_with_clear(16'd150);
    check("R9 in-window result with clear", 1'b0);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; res_valid = 1'b0; res_value = '0;
    thr_lo = '0; thr_hi = '1; pers_cfg = '0; irq_en = 1'b0; irq_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bounds();
    t_every();
    t_persist();
    t_break();
    t_sat();
    t_sticky();
    t_clear_count();
    t_clr_same();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule